// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the execute stage in a five-stage pipeline with 32 architectural registers, where the operand value comes from. It compares the two source register numbers of the instruction now in execute with the destination numbers of the two older instructions still in flight. The older instructions sit one stage ahead (memory) and two stages ahead (writeback). When an older instruction will write a register that the current instruction reads, its result is routed straight to the ALU and the stale register-file copy is not used.

The logic is purely combinational. It emits one 2-bit select code per operand and the selected operand value. Register zero never takes part in bypassing, because it is never written. An instruction that does not write a register is also ignored. When both older instructions target the same source register, the younger of the two (the one in the memory stage) wins.

Top module: `ex_operand_bypass`

## Requirements
- R1: With no matching in-flight write, an operand's select code is 2'b00 and the operand equals its register-file value (`src_a_val` or `src_b_val`).
- R2: When `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a_idx`, `sel_a` is 2'b10 and `alu_a` equals `exm_result`.
- R3: When `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_b_idx`, `sel_b` is 2'b10 and `alu_b` equals `exm_result`.
- R4: When only the writeback stage matches (`mwb_wr_en` is 1, `mwb_dst` is nonzero and equal to the source index), that operand's select code is 2'b01 and its value equals `mwb_result`.
- R5: A destination of register 0 never causes bypassing. A source index of 0 always yields select 2'b00.
- R6: A stage whose write enable is 0 never causes bypassing, even when its destination matches.
- R7: When both stages match the same operand, the memory-stage result wins and the code is 2'b10.
- R8: The two operands are resolved independently. Equal source indices always receive equal codes.
- R9: Outputs follow input changes within the same cycle, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the execute-stage instruction |
| src_b_idx | input | 5 | Second source register number of the execute-stage instruction |
| src_a_val | input | 32 | Register-file value for the first source |
| src_b_val | input | 32 | Register-file value for the second source |
| exm_dst | input | 5 | Destination register of the memory-stage instruction |
| exm_wr_en | input | 1 | Memory-stage instruction writes a register |
| exm_result | input | 32 | ALU result held in the memory stage |
| mwb_dst | input | 5 | Destination register of the writeback-stage instruction |
| mwb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| mwb_result | input | 32 | Value about to be written back |
| sel_a | output | 2 | Source code for operand A: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Source code for operand B, same encoding |
| alu_a | output | 32 | Selected operand A |
| alu_b | output | 32 | Selected operand B |

## Verification
The block holds no state, so any fault in the compare or priority logic shows on `sel_a`, `sel_b`, `alu_a` or `alu_b` in the same cycle as the input pattern that exercises it. Because no state is kept, a wrong result cannot hide and show up later. Each operand value is checked alongside its code, so a mux routing error is caught even when the code is right. The random mix draws register numbers from a small range, so that matches, double matches, register-zero destinations and equal source indices all occur often.

// File: rtl/ex_operand_bypass.sv
module ex_operand_bypass #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_a_idx,
  input  logic [REG_AW-1:0] src_b_idx,
  input  logic [DATA_W-1:0] src_a_val,
  input  logic [DATA_W-1:0] src_b_val,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              exm_wr_en,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic              mwb_wr_en,
  input  logic [DATA_W-1:0] mwb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [1:0] SEL_EXM = 2'b10;

  logic exm_live, mwb_live;
  assign exm_live = exm_wr_en && (exm_dst != '0);
  assign mwb_live = mwb_wr_en && (mwb_dst != '0);

  function automatic logic [1:0] pick(input logic [REG_AW-1:0] idx);
    if (exm_live && exm_dst == idx)      return SEL_EXM;
    else if (mwb_live && mwb_dst == idx) return SEL_MWB;
    else                                 return SEL_RF;
  endfunction

  function automatic logic [DATA_W-1:0] route(input logic [1:0] s,
                                              input logic [DATA_W-1:0] rf);
    case (s)
      SEL_EXM: return exm_result;
      SEL_MWB: return mwb_result;
      default: return rf;
    endcase
  endfunction

  assign sel_a = pick(src_a_idx);
  assign sel_b = pick(src_b_idx);
  assign alu_a = route(sel_a, src_a_val);
  assign alu_b = route(sel_b, src_b_val);

  always_comb begin
    if (!$isunknown({src_a_idx, src_b_idx, exm_dst, exm_wr_en, mwb_dst, mwb_wr_en,
                     sel_a, sel_b})) begin
      if (sel_a == SEL_RF)
        a_r1_rf_path: assert (alu_a == src_a_val);
      if (sel_a == SEL_EXM)
        a_r2_exm_value: assert (alu_a == exm_result && exm_dst == src_a_idx);
      if (sel_b == SEL_EXM)
        a_r3_exm_value_b: assert (alu_b == exm_result && exm_dst == src_b_idx);
      if (sel_b == SEL_MWB)
        a_r4_mwb_value_b: assert (alu_b == mwb_result && mwb_dst == src_b_idx);
      a_r5_zero_src: assert (src_a_idx != '0 || sel_a == SEL_RF);
      a_r6_no_writer: assert (exm_wr_en || mwb_wr_en || (sel_a == SEL_RF && sel_b == SEL_RF));
      if (sel_a == SEL_MWB)
        a_r7_newest_wins: assert (!(exm_wr_en && exm_dst == src_a_idx));
      a_r8_same_src: assert (src_a_idx != src_b_idx || sel_a == sel_b);
    end
  end

endmodule

// File: tb/test_ex_operand_bypass.sv
module test_ex_operand_bypass;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [4:0]  ra, rb, ed, md;
  logic        ew, mw;
  logic [31:0] va, vb, ev, mv;
  logic [1:0]  sa, sb;
  logic [31:0] oa, ob;
  int total = 0, bad = 0;
  bit finished = 0;

  ex_operand_bypass i_ex_operand_bypass (
    .src_a_idx(ra), .src_b_idx(rb), .src_a_val(va), .src_b_val(vb),
    .exm_dst(ed), .exm_wr_en(ew), .exm_result(ev),
    .mwb_dst(md), .mwb_wr_en(mw), .mwb_result(mv),
    .sel_a(sa), .sel_b(sb), .alu_a(oa), .alu_b(ob));

  function automatic logic [1:0] want_sel(input logic [4:0] idx);
    if (ew && ed != 0 && ed == idx) return 2'b10;
    if (mw && md != 0 && md == idx) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'b10) ? ev : (s == 2'b01) ? mv : rf;
  endfunction

  task automatic check(input string tag);
    logic [1:0] xa, xb;
    xa = want_sel(ra);
    xb = want_sel(rb);
    total++;
    if (sa !== xa || sb !== xb || oa !== want_val(xa, va) || ob !== want_val(xb, vb)) begin
      bad++;
      $display("FAIL %s: sel_a=%b sel_b=%b alu_a=%h alu_b=%h expected %b %b %h %h",
               tag, sa, sb, oa, ob, xa, xb, want_val(xa, va), want_val(xb, vb));
    end
  endtask

  task automatic apply(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] e, input logic ewe,
                       input logic [4:0] m, input logic mwe, input string tag);
    @(negedge clk);
    ra = a; rb = b; ed = e; ew = ewe; md = m; mw = mwe;
    va = $urandom; vb = $urandom; ev = $urandom; mv = $urandom;
    #2 check(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: expired expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    ra = 0; rb = 0; ed = 0; ew = 0; md = 0; mw = 0;
    va = 32'h11; vb = 32'h22; ev = 32'h33; mv = 32'h44;
    #3 check("R1 reset state");
    apply(5'd3, 5'd4, 5'd9, 1, 5'd10, 1, "R1 no match");
    apply(5'd2, 5'd5, 5'd2, 1, 5'd7, 0, "R2 ex hazard A");
    apply(5'd5, 5'd2, 5'd2, 1, 5'd7, 0, "R3 ex hazard B");
    apply(5'd6, 5'd1, 5'd9, 0, 5'd6, 1, "R4 mem hazard A");
    apply(5'd1, 5'd6, 5'd9, 0, 5'd6, 1, "R4 mem hazard B");
    apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, "R5 zero dest");
    apply(5'd4, 5'd4, 5'd4, 0, 5'd4, 0, "R6 no write enable");
    apply(5'd4, 5'd4, 5'd4, 0, 5'd4, 1, "R6 exm disabled falls to mwb");
    apply(5'd1, 5'd3, 5'd1, 1, 5'd1, 1, "R7 both match");
    apply(5'd0, 5'd8, 5'd0, 1, 5'd8, 1, "R5 R7 zero then mwb");
    apply(5'd7, 5'd7, 5'd7, 1, 5'd9, 1, "R8 equal sources");
    apply(5'd3, 5'd8, 5'd3, 1, 5'd8, 1, "R8 independent codes");
    @(negedge clk);
    ra = 5'd12; ed = 5'd12; ew = 1; ev = 32'hCAFE0001;
    #1 check("R9 same-cycle response");
    ed = 5'd13;
    #1 check("R9 same-cycle release");
    for (int i = 0; i < 3000; i++) begin
      logic full;
      full = ($urandom_range(0, 7) == 0);
      apply(full ? 5'($urandom) : 5'($urandom_range(0, 3)),
            full ? 5'($urandom) : 5'($urandom_range(0, 3)),
            full ? 5'($urandom) : 5'($urandom_range(0, 3)), 1'($urandom),
            full ? 5'($urandom) : 5'($urandom_range(0, 3)), 1'($urandom),
            "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end
    finish_run();
  end
endmodule